// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the instruction fetch unit and predicts the next fetch address in the same cycle that a fetch address is presented. It holds a small direct-mapped table. Each line stores the upper address bits of a branch, the address that branch last jumped to, and a 2-bit saturating confidence counter. A lookup is combinational: the fetch PC selects a line, and the outputs report a hit, a taken/not-taken guess and the address to fetch next.

When a branch resolves in the execute stage, the execute stage drives the update port with the branch PC, its outcome and its resolved target. The update is written on the next clock edge. It refreshes a line that already holds that branch, or it claims the line when a taken branch was not yet present. Branches that are never taken therefore never occupy a line.

Top module: `btb_predictor`

## Requirements
- R1: After reset every line is empty, so every lookup reports no hit, no taken guess and a next PC of fetch PC + 4.
- R2: A line gives a hit only when it is valid and its stored upper bits equal fetch PC bits [31:6]. A PC that maps to the same line with different upper bits is a miss and yields fetch PC + 4.
- R3: On a hit whose counter predicts taken, the next PC is the stored target in the same cycle, with no clock edge between presenting the PC and reading the prediction.
- R4: On a hit whose counter predicts not-taken, the hit output is 1, the taken output is 0 and the next PC is fetch PC + 4.
- R5: A taken update for a PC that misses claims its line with the counter at weakly taken. From the next cycle that PC hits and predicts the new target.
- R6: A not-taken update for a PC that misses changes nothing, and that PC still misses afterwards.
- R7: The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken, and its upper bit is the guess. A taken outcome steps the counter up and a not-taken outcome steps it down, saturating at 11 and at 00. A prediction therefore flips only after two consecutive contrary outcomes from a strong state.
- R8: A taken update to a line that hits overwrites the stored target. A not-taken update to a line that hits leaves the stored target as it was.
- R9: When an update and a lookup address the same line in one cycle, the lookup reports the contents from before the update.
- R10: The line index is PC bits [5:2], giving 16 lines. An update to one line does not alter the prediction of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears every valid bit |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | A valid line with matching upper bits exists for fetch_pc |
| pred_taken | output | 1 | Hit and the counter guesses taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The bench probes aliasing by presenting a PC that shares a line with an installed branch. A design that indexed without a full tag compare would redirect that PC to a foreign target. It walks one line through every counter state, including repeated outcomes at both ends. A counter that wrapped instead of saturating, or that flipped after one contrary outcome, would show the wrong guess at a known step. The bench also issues a not-taken update for an absent branch, where a design that claimed the line would report a hit. It fires a lookup in the same cycle as the allocating update, where a write-through design would report a hit one cycle early. A not-taken update carrying a bogus target shows any design that wrote the target on every update.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_W  = PC_W - TAG_LO;
  localparam logic [1:0] WEAK_T = 2'b10;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [1:0]       ctr_q [DEPTH];

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             u_hit, u_write;
  logic [1:0]       u_ctr_next;

  assign f_idx = fetch_pc[TAG_LO-1:2];
  assign f_tag = fetch_pc[PC_W-1:TAG_LO];
  assign u_idx = upd_pc[TAG_LO-1:2];
  assign u_tag = upd_pc[PC_W-1:TAG_LO];

  assign pred_hit     = vld[f_idx] && (tag_q[f_idx] == f_tag);
  assign pred_taken   = pred_hit && ctr_q[f_idx][1];
  assign pred_next_pc = pred_taken ? tgt_q[f_idx] : fetch_pc + PC_W'(4);

  assign u_hit   = vld[u_idx] && (tag_q[u_idx] == u_tag);
  assign u_write = upd_valid && (u_hit || upd_taken);

  always_comb begin
    u_ctr_next = ctr_q[u_idx];
    if (!u_hit)
      u_ctr_next = WEAK_T;
    else if (upd_taken && ctr_q[u_idx] != 2'b11)
      u_ctr_next = ctr_q[u_idx] + 2'd1;
    else if (!upd_taken && ctr_q[u_idx] != 2'b00)
      u_ctr_next = ctr_q[u_idx] - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld <= '0;
    else if (u_write)
      vld[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (u_write) begin
      tag_q[u_idx] <= u_tag;
      ctr_q[u_idx] <= u_ctr_next;
      if (upd_taken)
        tgt_q[u_idx] <= upd_target;
    end
  end
endmodule

module btb_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !pred_hit);

  assert_miss_falls_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> pred_next_pc == fetch_pc + PC_W'(4));

  assert_taken_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  assert_taken_update_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && upd_valid && upd_taken) && fetch_pc == $past(upd_pc)) |-> pred_hit);

  assert_nt_miss_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && upd_valid && !upd_taken && fetch_pc == upd_pc && !pred_hit)
     && $stable(fetch_pc)) |-> !pred_hit);
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int applied = 0;
  int miscompares = 0;

  localparam logic [31:0] PC_A  = 32'h0000_1000;
  localparam logic [31:0] PC_AL = 32'h0000_2000;
  localparam logic [31:0] PC_AM = 32'h0000_1040;
  localparam logic [31:0] PC_C  = 32'h0000_1004;
  localparam logic [31:0] TGT1  = 32'h0000_3000;
  localparam logic [31:0] TGT2  = 32'h0000_4400;
  localparam logic [31:0] TGT3  = 32'h0000_5008;
  localparam logic [31:0] BOGUS = 32'hDEAD_BEE0;

  btb_predictor dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_pred(string req, logic [31:0] pc, logic h, logic t, logic [31:0] nxt);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk(req, "hit", 32'(pred_hit), 32'(h));
    chk(req, "taken", 32'(pred_taken), 32'(t));
    chk(req, "next_pc", pred_next_pc, nxt);
  endtask

  task automatic update(logic [31:0] pc, logic tk, logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_pred("R1", PC_A, 1'b0, 1'b0, PC_A + 4);
    expect_pred("R1", PC_C, 1'b0, 1'b0, PC_C + 4);
  endtask

  task automatic t_nt_no_alloc;
    update(PC_A, 1'b0, TGT1);
    expect_pred("R6", PC_A, 1'b0, 1'b0, PC_A + 4);
  endtask

  task automatic t_alloc_and_alias;
    update(PC_A, 1'b1, TGT1);
    expect_pred("R5", PC_A, 1'b1, 1'b1, TGT1);
    expect_pred("R2", PC_AL, 1'b0, 1'b0, PC_AL + 4);
    expect_pred("R2", PC_AM, 1'b0, 1'b0, PC_AM + 4);
  endtask

  task automatic t_counter_walk;
    update(PC_A, 1'b1, TGT1);
    update(PC_A, 1'b0, BOGUS);
    expect_pred("R7", PC_A, 1'b1, 1'b1, TGT1);
    update(PC_A, 1'b0, BOGUS);
    expect_pred("R4", PC_A, 1'b1, 1'b0, PC_A + 4);
    update(PC_A, 1'b0, BOGUS);
    update(PC_A, 1'b0, BOGUS);
    update(PC_A, 1'b1, TGT2);
    expect_pred("R7", PC_A, 1'b1, 1'b0, PC_A + 4);
    update(PC_A, 1'b1, TGT2);
    expect_pred("R8", PC_A, 1'b1, 1'b1, TGT2);
    update(PC_A, 1'b1, TGT2);
    update(PC_A, 1'b1, TGT2);
    update(PC_A, 1'b0, BOGUS);
    expect_pred("R8", PC_A, 1'b1, 1'b1, TGT2);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fetch_pc = PC_C;
    upd_valid = 1'b1; upd_pc = PC_C; upd_taken = 1'b1; upd_target = TGT3;
    #1;
    chk("R9", "hit", 32'(pred_hit), 32'd0);
    chk("R9", "next_pc", pred_next_pc, PC_C + 4);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk("R9", "next_pc", pred_next_pc, TGT3);
    expect_pred("R10", PC_A, 1'b1, 1'b1, TGT2);
    expect_pred("R3", PC_C, 1'b1, 1'b1, TGT3);
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_pred("R1", PC_A, 1'b0, 1'b0, PC_A + 4);
    expect_pred("R1", PC_C, 1'b0, 1'b0, PC_C + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nt_no_alloc();
    t_alloc_and_alias();
    t_counter_walk();
    t_same_cycle();
    t_reset_again();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule